// File: doc/BRIEF.md
# DDR2 Control-Pin Command Decoder and Protocol Checker

This block watches the control pins of a DDR2 SDRAM interface. It sees chip select, the row and column strobes, write enable, clock enable, the bank address and address bit 10. On every rising clock edge it turns the pin state into one named command. It reports that command on an encoded output, together with the bank the command targets. The decoder reads clock enable as a pair of levels: the level at the previous edge and the level at the current edge. It also keeps track of whether the device is in power-down or self-refresh. Because of this, the same strobe pattern can stand for different commands.

Next to the decoder, a checker keeps the open or closed state of every bank, the bank of the burst of four currently running, and a count of the cycles spent in power-down. An illegal pin pattern or an illegal command sequence sets an error flag. The flag stays set until reset or a pulse on the re-initialization input. The block is meant to sit in a memory-controller subsystem as a passive protocol monitor.

Top module: `ddr2_cmd_mon`

## Requirements
- R1: With clock enable high at both the previous and the current edge, chip select high is reported as deselect (code 0). Chip select low with row strobe, column strobe and write enable all high is reported as no-operation (code 1).
- R2: With clock enable high at both edges and chip select low, the strobes {ras_n,cas_n,we_n} decode as follows: 000 mode-register set (2); 001 refresh (3); 010 precharge, reported as single-bank (6) when a10 is low and as all banks (7) when a10 is high; 011 activate (8); 100 write, reported as write (9) when a10 is low and as write with auto-precharge (10) when a10 is high; 101 read, reported as read (11) when a10 is low and as read with auto-precharge (12) when a10 is high. bank_o carries ba for codes 2, 6, 8, 9, 10, 11 and 12, and is 0 for every other code.
- R3: Clock enable falling from high to low decodes as follows: the refresh pattern is self-refresh entry (4); a no-operation or deselect pattern is power-down entry (13); any other pattern is illegal (15). While the device is in power-down or self-refresh, a cycle with clock enable low at both edges is reported as low-power hold (16).
- R4: Clock enable rising while the device is in self-refresh is self-refresh exit (5), whatever the other pins show. Clock enable rising while the device is in power-down is power-down exit (14) with a no-operation or deselect pattern, and illegal (15) with any other pattern.
- R5: cmd_o, bank_o and err_o are registered: the pins sampled at one edge show up on the outputs just after that edge. Reset gives code 0, bank 0 and no error.
- R6: An illegal decode (15), including the strobe pattern 110 with clock enable high at both edges, sets err_o. err_o then stays set until rst or reinit.
- R7: Activate opens its bank. Precharge closes one bank, precharge-all closes every bank, and read or write with auto-precharge closes its bank. An activate to an open bank sets err_o. A read or write to a closed bank sets err_o.
- R8: A refresh or a self-refresh entry while any bank is open sets err_o.
- R9: After a read or write, a read, write or single-bank precharge to the same bank, or a precharge-all, within the next BURST_CYC-1 edges sets err_o. A read or write to a different bank does not set it.
- R10: In power-down, each low-power hold cycle is counted. The hold cycle that comes after pd_limit hold cycles have already been counted sets err_o.
- R11: A reinit pulse returns the outputs to code 0, bank 0 and no error. It also closes all banks, leaves the low-power modes, and takes clock enable as high at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, pins sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Synchronous re-initialization, clears the error and all tracked state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BANK_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-banks / auto-precharge qualifier) |
| pd_limit | input | PD_CNT_W | Largest number of power-down hold cycles allowed |
| cmd_o | output | 5 | Decoded command code |
| bank_o | output | BANK_W | Bank targeted by the decoded command |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
Every strobe pattern is driven with clock enable steady high. Two cases show whether a10 is read as a qualifier: a10 low and a10 high on precharge, and both levels on read and write. The same patterns are then driven on a falling clock-enable edge and on a rising one. This separates entry from exit and power-down from self-refresh. It also shows that a self-refresh exit ignores the strobes, while a power-down exit with an activate pattern is rejected. Sequence patterns tell legal bank use apart from an activate to an open bank, an access to a closed bank, a refresh with an open bank, and a back-to-back burst to the same bank as opposed to a different bank. Separate power-down runs check that the hold-cycle limit is exact: the last allowed hold cycle raises no error, and the one after it does.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;
  typedef enum logic [4:0] {
    CMD_DESEL = 5'd0,
    CMD_NOP   = 5'd1,
    CMD_MRS   = 5'd2,
    CMD_REF   = 5'd3,
    CMD_SRE   = 5'd4,
    CMD_SRX   = 5'd5,
    CMD_PRE   = 5'd6,
    CMD_PREA  = 5'd7,
    CMD_ACT   = 5'd8,
    CMD_WR    = 5'd9,
    CMD_WRA   = 5'd10,
    CMD_RD    = 5'd11,
    CMD_RDA   = 5'd12,
    CMD_PDE   = 5'd13,
    CMD_PDX   = 5'd14,
    CMD_ILL   = 5'd15,
    CMD_HOLD  = 5'd16
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_PWRDN   = 2'd1,
    MODE_SELFREF = 2'd2
  } mode_e;
endpackage

// File: rtl/ddr2_pin_decode.sv
module ddr2_pin_decode
  import ddr2_cmd_pkg::*;
(
  input  logic  cs_n,
  input  logic  ras_n,
  input  logic  cas_n,
  input  logic  we_n,
  input  logic  cke_prev,
  input  logic  cke,
  input  logic  a10,
  input  mode_e mode,
  output cmd_e  cmd
);
  logic [2:0] rcw;
  logic       idle_pat;
  logic       ref_pat;

  assign rcw      = {ras_n, cas_n, we_n};
  assign idle_pat = cs_n || (rcw == 3'b111);
  assign ref_pat  = !cs_n && (rcw == 3'b001);

  always_comb begin
    cmd = CMD_ILL;
    case ({cke_prev, cke})
      2'b11: begin
        if (cs_n) begin
          cmd = CMD_DESEL;
        end else begin
          case (rcw)
            3'b111:  cmd = CMD_NOP;
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_REF;
            3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
            3'b011:  cmd = CMD_ACT;
            3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
            3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
            default: cmd = CMD_ILL;
          endcase
        end
      end
      2'b10: begin
        if (ref_pat)       cmd = CMD_SRE;
        else if (idle_pat) cmd = CMD_PDE;
        else               cmd = CMD_ILL;
      end
      2'b01: begin
        if (mode == MODE_SELFREF)                cmd = CMD_SRX;
        else if (mode == MODE_PWRDN && idle_pat) cmd = CMD_PDX;
        else                                     cmd = CMD_ILL;
      end
      default: begin
        cmd = (mode != MODE_NORMAL) ? CMD_HOLD : CMD_ILL;
      end
    endcase
  end
endmodule

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track #(
  parameter int BANK_W = 3,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              open_req,
  input  logic              close_one,
  input  logic              close_all,
  input  logic [BANK_W-1:0] bank,
  output logic [NBANK-1:0]  open_o
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(g));
    always_ff @(posedge clk) begin
      if (clr)                            open_o[g] <= 1'b0;
      else if (close_all)                 open_o[g] <= 1'b0;
      else if (hit && close_one)          open_o[g] <= 1'b0;
      else if (hit && open_req)           open_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard #(
  parameter int BANK_W    = 3,
  parameter int BURST_CYC = 2,
  localparam int BC_W     = $clog2(BURST_CYC + 1)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              start,
  input  logic              hit_bank_cmd,
  input  logic              hit_any_cmd,
  input  logic [BANK_W-1:0] bank,
  output logic              conflict
);
  logic [BC_W-1:0]   left_q;
  logic [BANK_W-1:0] bank_q;
  logic              busy;

  assign busy     = (left_q != '0);
  assign conflict = busy && (hit_any_cmd || (hit_bank_cmd && bank == bank_q));

  always_ff @(posedge clk) begin
    if (clr) begin
      left_q <= '0;
      bank_q <= '0;
    end else if (start) begin
      left_q <= BC_W'(BURST_CYC - 1);
      bank_q <= bank;
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ddr2_pd_timer.sv
module ddr2_pd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             over
);
  logic [CNT_W-1:0] cnt_q;

  assign over = tick && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (clr || start)                cnt_q <= '0;
    else if (tick && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ddr2_cmd_mon.sv
module ddr2_cmd_mon
  import ddr2_cmd_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int BURST_CYC = 2,
  parameter int PD_CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reinit,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                cke,
  input  logic [BANK_W-1:0]   ba,
  input  logic                a10,
  input  logic [PD_CNT_W-1:0] pd_limit,
  output logic [4:0]          cmd_o,
  output logic [BANK_W-1:0]   bank_o,
  output logic                err_o
);
  localparam int NBANK = 1 << BANK_W;

  logic             clr;
  logic             cke_q;
  mode_e            mode_q;
  cmd_e             dec_cmd;
  cmd_e             cmd_q;
  logic [NBANK-1:0] open_vec;
  logic             any_open;
  logic             is_rdwr;
  logic             has_bank;
  logic             conflict;
  logic             pd_over;
  logic             err_now;

  assign clr      = rst || reinit;
  assign any_open = |open_vec;
  assign is_rdwr  = (dec_cmd == CMD_WR) || (dec_cmd == CMD_WRA) ||
                    (dec_cmd == CMD_RD) || (dec_cmd == CMD_RDA);
  assign has_bank = is_rdwr || (dec_cmd == CMD_MRS) || (dec_cmd == CMD_PRE) ||
                    (dec_cmd == CMD_ACT);

  ddr2_pin_decode u_decode (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke_prev (cke_q),
    .cke      (cke),
    .a10      (a10),
    .mode     (mode_q),
    .cmd      (dec_cmd)
  );

  ddr2_bank_track #(.BANK_W(BANK_W)) u_banks (
    .clk       (clk),
    .clr       (clr),
    .open_req  (dec_cmd == CMD_ACT),
    .close_one ((dec_cmd == CMD_PRE) || (dec_cmd == CMD_WRA) || (dec_cmd == CMD_RDA)),
    .close_all (dec_cmd == CMD_PREA),
    .bank      (ba),
    .open_o    (open_vec)
  );

  ddr2_burst_guard #(.BANK_W(BANK_W), .BURST_CYC(BURST_CYC)) u_burst (
    .clk          (clk),
    .clr          (clr),
    .start        (is_rdwr),
    .hit_bank_cmd (is_rdwr || (dec_cmd == CMD_PRE)),
    .hit_any_cmd  (dec_cmd == CMD_PREA),
    .bank         (ba),
    .conflict     (conflict)
  );

  ddr2_pd_timer #(.CNT_W(PD_CNT_W)) u_pdtim (
    .clk   (clk),
    .clr   (clr),
    .start (dec_cmd == CMD_PDE),
    .tick  ((dec_cmd == CMD_HOLD) && (mode_q == MODE_PWRDN)),
    .limit (pd_limit),
    .over  (pd_over)
  );

  assign err_now = (dec_cmd == CMD_ILL) ||
                   ((dec_cmd == CMD_ACT) && open_vec[ba]) ||
                   (is_rdwr && !open_vec[ba]) ||
                   (((dec_cmd == CMD_REF) || (dec_cmd == CMD_SRE)) && any_open) ||
                   conflict || pd_over;

  always_ff @(posedge clk) begin
    if (clr) begin
      cke_q  <= 1'b1;
      mode_q <= MODE_NORMAL;
      cmd_q  <= CMD_DESEL;
      bank_o <= '0;
      err_o  <= 1'b0;
    end else begin
      cke_q  <= cke;
      cmd_q  <= dec_cmd;
      bank_o <= has_bank ? ba : '0;
      err_o  <= err_o || err_now;
      case (dec_cmd)
        CMD_SRE: mode_q <= MODE_SELFREF;
        CMD_PDE: mode_q <= MODE_PWRDN;
        default: mode_q <= cke ? MODE_NORMAL : mode_q;
      endcase
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/ddr2_cmd_mon_chk.sv
module ddr2_cmd_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       reinit,
  input logic       cs_n,
  input logic       cke,
  input logic       cke_q,
  input logic [1:0] mode_q,
  input logic [4:0] cmd_o,
  input logic       err_o
);
  localparam logic [1:0] SELFREF = 2'd2;
  localparam logic [1:0] NORMAL  = 2'd0;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cmd_o == 5'd0) && !err_o); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o && !reinit |=> err_o); // R6

  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 5'd15) |-> err_o); // R6

  AST_REINIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    reinit |=> !err_o && (cmd_o == 5'd0)); // R11

  AST_SELFREF_EXIT: assert property (@(posedge clk) disable iff (rst)
    !reinit && (mode_q == SELFREF) && cke |=> (cmd_o == 5'd5)); // R4

  AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !reinit && (mode_q == NORMAL) && cke_q && cke && cs_n |=> (cmd_o == 5'd0)); // R1
endmodule

bind ddr2_cmd_mon ddr2_cmd_mon_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .reinit (reinit),
  .cs_n   (cs_n),
  .cke    (cke),
  .cke_q  (cke_q),
  .mode_q (mode_q),
  .cmd_o  (cmd_o),
  .err_o  (err_o)
);

// File: tb/ddr2_cmd_mon_bench.sv
module ddr2_cmd_mon_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reinit = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic        cke = 1'b1;
  logic [2:0]  ba = '0;
  logic        a10 = 1'b0;
  logic [15:0] pd_limit = 16'd3;
  logic [4:0]  cmd_o;
  logic [2:0]  bank_o;
  logic        err_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int         due;
    logic [4:0] cmd;
    logic [2:0] bank;
    logic       err;
    string      tag;
  } exp_t;
  exp_t q[$];

  ddr2_cmd_mon u_ddr2_cmd_mon (
    .clk(clk), .rst(rst), .reinit(reinit), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
    .pd_limit(pd_limit), .cmd_o(cmd_o), .bank_o(bank_o), .err_o(err_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items once their edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (cmd_o !== e.cmd || bank_o !== e.bank || err_o !== e.err) begin
        fails++;
        $display("FAIL %s: cmd=%0d bank=%0d err=%0b expected cmd=%0d bank=%0d err=%0b",
                 e.tag, cmd_o, bank_o, err_o, e.cmd, e.bank, e.err);
      end
    end
  end

  task automatic push(input int ecmd, input int ebank, input logic eerr, input string tag);
    exp_t e;
    e.due = cyc + 1; e.cmd = 5'(ecmd); e.bank = 3'(ebank); e.err = eerr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic cs, input logic [2:0] rcw, input logic ck,
                      input int b, input logic a, input int ecmd, input int ebank,
                      input logic eerr, input string tag);
    @(negedge clk);
    reinit = 1'b0;
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; cke = ck; ba = 3'(b); a10 = a;
    push(ecmd, ebank, eerr, tag);
  endtask

  task automatic do_reinit();
    @(negedge clk);
    reinit = 1'b1;
    cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111; cke = 1'b1; ba = '0; a10 = 1'b0;
    push(0, 0, 1'b0, "R11 reinit");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (cmd_o !== 5'd0 || bank_o !== 3'd0 || err_o !== 1'b0) begin
      fails++;
      $display("FAIL R5 reset: cmd=%0d bank=%0d err=%0b expected 0 0 0", cmd_o, bank_o, err_o);
    end
    rst = 1'b0;
    cs_n = 1'b0;

    // R1 / R2 decode with steady-high clock enable
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(1, 3'b000, 1, 0, 0, 0, 0, 0, "R1 deselect");
    step(0, 3'b000, 1, 2, 0, 2, 2, 0, "R2 mode set");
    step(0, 3'b011, 1, 3, 0, 8, 3, 0, "R2 activate");
    step(0, 3'b111, 1, 3, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b101, 1, 3, 0, 11, 3, 0, "R2 read");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b100, 1, 3, 1, 10, 3, 0, "R7 write autoprecharge");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b101, 1, 3, 0, 11, 3, 1, "R7 read closed bank");
    do_reinit();

    // R7 double activate
    step(0, 3'b011, 1, 1, 0, 8, 1, 0, "R7 activate");
    step(0, 3'b011, 1, 1, 0, 8, 1, 1, "R7 activate open bank");
    do_reinit();

    // R2 precharge variants, R7 reopen, R8 legal refresh
    step(0, 3'b011, 1, 5, 0, 8, 5, 0, "R2 activate");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b010, 1, 5, 0, 6, 5, 0, "R2 precharge one");
    step(0, 3'b011, 1, 5, 0, 8, 5, 0, "R7 reopen after precharge");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b010, 1, 5, 1, 7, 0, 0, "R2 precharge all");
    step(0, 3'b001, 1, 0, 0, 3, 0, 0, "R8 refresh all closed");
    step(0, 3'b011, 1, 0, 0, 8, 0, 0, "R2 activate");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b001, 1, 0, 0, 3, 0, 1, "R8 refresh bank open");
    do_reinit();

    // R6 illegal strobe pattern, sticky
    step(0, 3'b110, 1, 0, 0, 15, 0, 1, "R6 illegal pattern");
    step(0, 3'b111, 1, 0, 0, 1, 0, 1, "R6 sticky error");
    step(1, 3'b111, 1, 0, 0, 0, 0, 1, "R6 sticky error");
    do_reinit();

    // R9 burst guard
    step(0, 3'b011, 1, 2, 0, 8, 2, 0, "R9 activate");
    step(0, 3'b011, 1, 4, 0, 8, 4, 0, "R9 activate");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b101, 1, 2, 0, 11, 2, 0, "R9 read");
    step(0, 3'b100, 1, 4, 0, 9, 4, 0, "R9 other bank write");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop");
    step(0, 3'b101, 1, 2, 0, 11, 2, 0, "R9 read after gap");
    step(0, 3'b101, 1, 2, 0, 11, 2, 1, "R9 same bank back to back");
    do_reinit();

    // R3 / R10 power-down limit
    step(0, 3'b111, 0, 0, 0, 13, 0, 0, "R3 power-down entry");
    step(0, 3'b111, 0, 0, 0, 16, 0, 0, "R10 hold 1");
    step(0, 3'b111, 0, 0, 0, 16, 0, 0, "R10 hold 2");
    step(0, 3'b111, 0, 0, 0, 16, 0, 0, "R10 hold 3 at limit");
    step(0, 3'b111, 0, 0, 0, 16, 0, 1, "R10 hold 4 over limit");
    do_reinit();

    // R4 legal power-down exit
    step(0, 3'b111, 0, 0, 0, 13, 0, 0, "R3 power-down entry");
    step(0, 3'b111, 0, 0, 0, 16, 0, 0, "R3 hold");
    step(0, 3'b111, 1, 0, 0, 14, 0, 0, "R4 power-down exit");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop after exit");

    // R3 deselect entry, R4 exit with wrong pattern
    step(1, 3'b111, 0, 0, 0, 13, 0, 0, "R3 power-down entry by deselect");
    step(0, 3'b011, 1, 0, 0, 15, 0, 1, "R4 exit with activate pattern");
    do_reinit();

    // R3 / R4 self-refresh
    step(0, 3'b001, 0, 0, 0, 4, 0, 0, "R3 self-refresh entry");
    step(0, 3'b111, 0, 0, 0, 16, 0, 0, "R3 self-refresh hold");
    step(0, 3'b111, 0, 0, 0, 16, 0, 0, "R3 self-refresh hold");
    step(0, 3'b101, 1, 6, 0, 5, 0, 0, "R4 self-refresh exit any pins");
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R1 nop after exit");

    // R3 bad falling-edge pattern
    step(0, 3'b011, 0, 0, 0, 15, 0, 1, "R3 illegal entry pattern");
    do_reinit();
    step(0, 3'b111, 1, 0, 0, 1, 0, 0, "R11 nop after reinit");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule